// File: doc/BRIEF.md
# Scaled 64-bit System Counter

This block keeps a 64-bit unsigned up-counter that advances on each qualified counter tick. With scaling off it moves by exactly one per tick. With scaling on it adds an unsigned fixed-point increment per tick. The increment has 8 integer bits and 24 fractional bits. A hidden 24-bit fraction accumulator holds the fractional part, and its carry goes into the integer count in the same cycle. Two increment registers are preloaded, one for each of two clock sources, and a select input picks the active one. Software can change clock source without reprogramming the rate.

The counter is controlled through a 32-bit APB-style register frame with zero-wait access. The frame has these word addresses: control at 0x00, status at 0x04, count low word at 0x08, count high word at 0x0C, scale register 0 at 0x10, scale register 1 at 0x14 and identification at 0x18. Any other address, including an address that is not word aligned, is a decode error. The status and identification words are read-only; writes to them are ignored and raise no error. An access flagged as a security mismatch, or an access that fails decode, sets a pending error flag. Such an access can also return a slave-error response. The error interrupt is the pending flag gated by the mask bit.

Top module: `scaled_sys_counter`

## Requirements
- R1: After reset the count is 0, the control word reads 0, the error flag is clear, and both scale registers read 0x0100_0000 (1.0).
- R2: With control bit 0 (enable) set, the count rises by exactly one on each clock edge where `tick_i` is high and scaling is off. With enable clear, or with `tick_i` low, the count holds.
- R3: With control bit 2 (scale enable) set, each tick adds the active scale value. The value has its integer part in bits [31:24] and its fraction in bits [23:0]. After k ticks from reset the count equals floor(k·S / 2^24).
- R4: `src_sel_i` = 0 selects scale register 0 and `src_sel_i` = 1 selects scale register 1. Identification bits [18:17] read back {0, `src_sel_i`}.
- R5: While the counter is enabled and the override parameter is 0, writes to either scale register are ignored.
- R6: A write to the low or high count word loads that half on the closing edge of the access and replaces that cycle's increment. The other half keeps its value. A carry out of the low word propagates into the high word.
- R7: With control bit 1 (halt on debug) set and `dbg_halt_i` high, the count holds and status bit 1 reads 1. Otherwise status bit 1 reads 0.
- R8: An access to an undecoded address returns read data 0. It asserts `pslverr` during the access phase unless control bit 4 (bus error disable) is set.
- R9: An access with `sec_err_i` high has no effect on any register, returns read data 0 and is treated as an error like R8.
- R10: Any error access sets the pending flag whatever the mask. `irq_o` equals the pending flag AND control bit 3 (mask). Writing a 1 to control bit 5 clears the flag, and bit 5 always reads 0.
- R11: Identification bit 0 reads 1 when scaling is built in, bit 16 reads 1 when clock switching is built in, and bit 19 reads the scale-write override. Under default parameters the word reads 0x0001_0001 with source 0 selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter tick qualifier |
| dbg_halt_i | input | 1 | Debug halt request |
| src_sel_i | input | 1 | Active clock source, picks scale register |
| psel | input | 1 | Frame select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | ADDR_W | Byte address within the frame |
| pwdata | input | 32 | Write data |
| sec_err_i | input | 1 | Security attribute mismatch for this access |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Error response, valid in the access phase |
| count_o | output | 64 | Current count |
| irq_o | output | 1 | Error interrupt |

## Verification
Read data and `pslverr` depend only on logic during the access phase. The bench therefore samples them one nanosecond after the enabling falling edge, inside that phase. Register writes, count loads and flag changes appear after the rising edge that closes the access, and each tick moves the count on the rising edge where `tick_i` is high. The bench drives inputs on falling edges and samples `count_o`, `irq_o` and read-backs on the next falling edge, after the edge that applied the stimulus. In the scale sweeps the bench resets first, so the fraction starts at zero and the expected count is plain integer arithmetic over the tick count.

// File: rtl/scnt_pkg.sv
package scnt_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned NUM_SRC = 2;

   // control bit positions: software depends on these
   localparam int unsigned B_ENABLE  = 0;
   localparam int unsigned B_HALTDBG = 1;
   localparam int unsigned B_SCALEEN = 2;
   localparam int unsigned B_MASK    = 3;
   localparam int unsigned B_ERRDIS  = 4;
   localparam int unsigned B_CLEAR   = 5;

   typedef enum logic [2:0] {
      RS_CTRL  = 3'd0,
      RS_STAT  = 3'd1,
      RS_CLO   = 3'd2,
      RS_CHI   = 3'd3,
      RS_SC0   = 3'd4,
      RS_SC1   = 3'd5,
      RS_ID    = 3'd6,
      RS_NONE  = 3'd7
   } reg_sel_e;

   typedef struct packed {
      logic err_dis;
      logic irq_mask;
      logic scale_en;
      logic halt_dbg;
      logic enable;
   } ctrl_t;
endpackage

// File: rtl/scnt_regbank.sv
module scnt_regbank
   import scnt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned INT_W      = 8,
   parameter int unsigned FRAC_W     = 24,
   parameter int unsigned CNT_W      = 64,
   parameter bit          SCALE_IMPL = 1'b1,
   parameter bit          CLKSW_IMPL = 1'b1,
   parameter bit          SCALE_OVR  = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    psel,
   input  logic                    penable,
   input  logic                    pwrite,
   input  logic [ADDR_W-1:0]       paddr,
   input  logic [WORD_W-1:0]       pwdata,
   input  logic                    sec_err_i,
   input  logic                    src_sel_i,
   input  logic [CNT_W-1:0]        cnt_i,
   input  logic                    halted_i,
   output logic [WORD_W-1:0]       prdata,
   output logic                    pslverr,
   output ctrl_t                   ctrl_o,
   output logic [INT_W+FRAC_W-1:0] scale_o,
   output logic                    wr_lo_o,
   output logic                    wr_hi_o,
   output logic                    irq_o
);
   localparam int unsigned SC_W   = INT_W + FRAC_W;
   localparam int unsigned IDX_W  = ADDR_W - 2;
   localparam logic [SC_W-1:0] SCALE_ONE = SC_W'(1) << FRAC_W;

   ctrl_t                           ctrl_q;
   logic [NUM_SRC-1:0][SC_W-1:0]    scale_q;
   logic                            pend_q;
   reg_sel_e                        sel;
   logic                            acc, dec_err, err, wr_ok, lock;

   always_comb begin
      sel = RS_NONE;
      if (paddr[1:0] == 2'b00) begin
         case (paddr[ADDR_W-1:2])
            IDX_W'(0): sel = RS_CTRL;
            IDX_W'(1): sel = RS_STAT;
            IDX_W'(2): sel = RS_CLO;
            IDX_W'(3): sel = RS_CHI;
            IDX_W'(4): sel = RS_SC0;
            IDX_W'(5): sel = RS_SC1;
            IDX_W'(6): sel = RS_ID;
            default:   sel = RS_NONE;
         endcase
      end
   end

   assign acc     = psel & penable;
   assign dec_err = (sel == RS_NONE);
   assign err     = acc & (dec_err | sec_err_i);
   assign wr_ok   = acc & pwrite & ~dec_err & ~sec_err_i;
   assign lock    = ctrl_q.enable & ~SCALE_OVR;
   assign wr_lo_o = wr_ok & (sel == RS_CLO);
   assign wr_hi_o = wr_ok & (sel == RS_CHI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ok && sel == RS_CTRL) begin
         ctrl_q <= ctrl_t'(pwdata[B_ERRDIS:B_ENABLE]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) scale_q[i] <= SCALE_ONE;
      end else if (wr_ok && !lock) begin
         for (int i = 0; i < NUM_SRC; i++)
            if (sel == reg_sel_e'(int'(RS_SC0) + i)) scale_q[i] <= pwdata[SC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                             pend_q <= 1'b0;
      else if (err)                                           pend_q <= 1'b1;
      else if (wr_ok && sel == RS_CTRL && pwdata[B_CLEAR])    pend_q <= 1'b0;
   end

   always_comb begin
      prdata = '0;
      if (acc && !pwrite && !err) begin
         case (sel)
            RS_CTRL: prdata = WORD_W'(ctrl_q);
            RS_STAT: prdata = WORD_W'({halted_i, 1'b0});
            RS_CLO:  prdata = cnt_i[WORD_W-1:0];
            RS_CHI:  prdata = cnt_i[CNT_W-1:WORD_W];
            RS_SC0:  prdata = WORD_W'(scale_q[0]);
            RS_SC1:  prdata = WORD_W'(scale_q[1]);
            RS_ID:   prdata = WORD_W'({SCALE_OVR, 1'b0, src_sel_i, CLKSW_IMPL,
                                       15'd0, SCALE_IMPL});
            default: prdata = '0;
         endcase
      end
   end

   assign pslverr = err & ~ctrl_q.err_dis;
   assign ctrl_o  = ctrl_q;
   assign scale_o = scale_q[src_sel_i];
   assign irq_o   = pend_q & ctrl_q.irq_mask;

   p_scale_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && pwrite && ctrl_q.enable && !SCALE_OVR) |=> (scale_q == $past(scale_q)));
   p_err_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> pend_q);
   p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ctrl_q.irq_mask);
   p_errresp_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> (acc && !ctrl_q.err_dis));
   p_sec_noeffect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && sec_err_i) |=> (ctrl_q == $past(ctrl_q)));
endmodule

// File: rtl/scnt_accum.sv
module scnt_accum
   import scnt_pkg::*;
#(
   parameter int unsigned CNT_W      = 64,
   parameter int unsigned INT_W      = 8,
   parameter int unsigned FRAC_W     = 24,
   parameter bit          SCALE_IMPL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    inc_en_i,
   input  logic                    scale_en_i,
   input  logic [INT_W+FRAC_W-1:0] scale_i,
   input  logic                    wr_lo_i,
   input  logic                    wr_hi_i,
   input  logic [WORD_W-1:0]       wdata_i,
   output logic [CNT_W-1:0]        cnt_o
);
   localparam int unsigned HALF = CNT_W / 2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] step;
   logic             load;

   assign load = wr_lo_i | wr_hi_i;

   if (SCALE_IMPL) begin : g_scaled
      logic [FRAC_W-1:0] frac_q;
      logic [FRAC_W:0]   frac_sum;

      assign frac_sum = {1'b0, frac_q} + {1'b0, scale_i[FRAC_W-1:0]};
      assign step = scale_en_i
                  ? CNT_W'(scale_i[INT_W+FRAC_W-1:FRAC_W]) + CNT_W'(frac_sum[FRAC_W])
                  : CNT_W'(1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                frac_q <= '0;
         else if (inc_en_i && scale_en_i && !load)  frac_q <= frac_sum[FRAC_W-1:0];
      end
   end else begin : g_unit
      assign step = CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (wr_lo_i)  cnt_q[HALF-1:0]     <= wdata_i;
      else if (wr_hi_i)  cnt_q[CNT_W-1:HALF] <= wdata_i;
      else if (inc_en_i) cnt_q <= cnt_q + step;
   end

   assign cnt_o = cnt_q;

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_en_i && !load) |=> (cnt_q == $past(cnt_q)));
   p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en_i && !scale_en_i && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_load_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_i |=> (cnt_q[HALF-1:0] == $past(wdata_i)
                   && cnt_q[CNT_W-1:HALF] == $past(cnt_q[CNT_W-1:HALF])));
   p_load_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_i && !wr_lo_i) |=> (cnt_q[CNT_W-1:HALF] == $past(wdata_i)));
endmodule

// File: rtl/scaled_sys_counter.sv
module scaled_sys_counter
   import scnt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned CNT_W      = 64,
   parameter int unsigned INT_W      = 8,
   parameter int unsigned FRAC_W     = 24,
   parameter bit          SCALE_IMPL = 1'b1,
   parameter bit          CLKSW_IMPL = 1'b1,
   parameter bit          SCALE_OVR  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              dbg_halt_i,
   input  logic              src_sel_i,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   input  logic              sec_err_i,
   output logic [31:0]       prdata,
   output logic              pslverr,
   output logic [63:0]       count_o,
   output logic              irq_o
);
   localparam int unsigned SC_W = INT_W + FRAC_W;

   if (CNT_W != 2 * WORD_W) begin : g_bad_cnt
      $error("count must be exactly two register words wide");
   end
   if (SC_W != WORD_W) begin : g_bad_scale
      $error("scale integer and fraction widths must fill one word");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("address too narrow for the register frame");
   end

   ctrl_t             ctrl;
   logic [SC_W-1:0]   scale;
   logic              wr_lo, wr_hi, halted, run;
   logic [CNT_W-1:0]  cnt;

   assign halted = ctrl.enable & ctrl.halt_dbg & dbg_halt_i;
   assign run    = ctrl.enable & tick_i & ~(ctrl.halt_dbg & dbg_halt_i);

   scnt_regbank #(
      .ADDR_W(ADDR_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W),
      .SCALE_IMPL(SCALE_IMPL), .CLKSW_IMPL(CLKSW_IMPL), .SCALE_OVR(SCALE_OVR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .sec_err_i(sec_err_i), .src_sel_i(src_sel_i),
      .cnt_i(cnt), .halted_i(halted), .prdata(prdata), .pslverr(pslverr),
      .ctrl_o(ctrl), .scale_o(scale), .wr_lo_o(wr_lo), .wr_hi_o(wr_hi), .irq_o(irq_o)
   );

   scnt_accum #(
      .CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .SCALE_IMPL(SCALE_IMPL)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .inc_en_i(run), .scale_en_i(ctrl.scale_en),
      .scale_i(scale), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(pwdata),
      .cnt_o(cnt)
   );

   assign count_o = cnt;

   p_debug_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !wr_lo && !wr_hi) |=> (count_o == $past(count_o)));
endmodule

// File: tb/tb_scaled_sys_counter.sv
`timescale 1ns/1ps
module tb_scaled_sys_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0, dbg_halt_i = 1'b0, src_sel_i = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, sec_err_i = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pslverr;
   logic [63:0] count_o;
   logic        irq_o;

   int total = 0, bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   scaled_sys_counter dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dbg_halt_i(dbg_halt_i),
      .src_sel_i(src_sel_i), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .sec_err_i(sec_err_i), .prdata(prdata),
      .pslverr(pslverr), .count_o(count_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
   endtask

   // setup phase, access phase (sampled 1ns in), ends one negedge after the closing edge
   task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input bit sec, output logic [31:0] rd, output logic er);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; sec_err_i = sec;
      @(negedge clk);
      penable = 1'b1;
      #1;
      rd = prdata; er = pslverr;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0; sec_err_i = 1'b0;
   endtask

   task automatic wr32(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] rd; logic er;
      bus(1'b1, a, d, 1'b0, rd, er);
   endtask

   task automatic rd32(input logic [7:0] a, output logic [31:0] rd);
      logic er;
      bus(1'b0, a, '0, 1'b0, rd, er);
   endtask

   task automatic do_ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      logic [31:0] rd;
      logic        er;
      logic [63:0] exp;

      do_reset();
      // R1 reset state
      chk("R1 count", count_o, 64'd0);
      rd32(8'h00, rd); chk("R1 ctrl", 64'(rd), 64'd0);
      rd32(8'h10, rd); chk("R1 scale0", 64'(rd), 64'h0100_0000);
      rd32(8'h14, rd); chk("R1 scale1", 64'(rd), 64'h0100_0000);
      chk("R1 irq", 64'(irq_o), 64'd0);
      // R11 identification
      rd32(8'h18, rd); chk("R11 id sel0", 64'(rd), 64'h0001_0001);
      src_sel_i = 1'b1;
      rd32(8'h18, rd); chk("R4 id sel1", 64'(rd), 64'h0003_0001);
      src_sel_i = 1'b0;

      // R2 disabled holds
      do_ticks(4); chk("R2 disabled hold", count_o, 64'd0);
      // R2 unit step sweep with gaps
      wr32(8'h00, 32'h1);
      exp = 0;
      for (int i = 1; i <= 6; i++) begin
         do_ticks(i); exp += 64'(i);
         repeat (i) @(negedge clk);
         chk($sformatf("R2 unit n=%0d", i), count_o, exp);
      end
      // R5 lock while enabled
      wr32(8'h10, 32'h1234_5678);
      rd32(8'h10, rd); chk("R5 scale0 locked", 64'(rd), 64'h0100_0000);
      wr32(8'h14, 32'h0ABC_0000);
      rd32(8'h14, rd); chk("R5 scale1 locked", 64'(rd), 64'h0100_0000);

      // R7 debug halt
      wr32(8'h00, 32'h3);
      dbg_halt_i = 1'b1;
      exp = count_o;
      do_ticks(5); chk("R7 halted hold", count_o, exp);
      rd32(8'h04, rd); chk("R7 status set", 64'(rd), 64'h2);
      dbg_halt_i = 1'b0;
      do_ticks(5); chk("R7 resume", count_o, exp + 5);
      rd32(8'h04, rd); chk("R7 status clear", 64'(rd), 64'h0);
      wr32(8'h00, 32'h1);
      dbg_halt_i = 1'b1;
      do_ticks(3); chk("R7 no halt bit counts", count_o, exp + 8);
      dbg_halt_i = 1'b0;

      // R6 count write and carry into the high word
      wr32(8'h00, 32'h0);
      wr32(8'h08, 32'hFFFF_FFFE);
      wr32(8'h0C, 32'h0000_0007);
      chk("R6 loaded", count_o, 64'h7_FFFF_FFFE);
      wr32(8'h00, 32'h1);
      do_ticks(3); chk("R6 carry", count_o, 64'h8_0000_0001);
      // R6 load overrides a tick in the same cycle
      tick_i = 1'b1;
      wr32(8'h08, 32'h0000_0100);
      tick_i = 1'b0;
      chk("R6 load beats tick", count_o, 64'h8_0000_0100);

      // R3/R4 scaled sweep
      for (int s = 0; s < 6; s++) begin
         for (int src = 0; src < 2; src++) begin
            logic [31:0] sv;
            sv = 32'h0040_0000 + 32'(s) * 32'h015A_3C11;
            do_reset();
            src_sel_i = src[0];
            wr32(src ? 8'h14 : 8'h10, sv);
            wr32(src ? 8'h10 : 8'h14, 32'h0700_0000);
            wr32(8'h00, 32'h5);
            do_ticks(37);
            exp = (64'd37 * 64'(sv)) >> 24;
            chk($sformatf("R3 R4 scale=%h src=%0d", sv, src), count_o, exp);
         end
      end
      src_sel_i = 1'b0;

      // R8 decode error, R10 pending and mask
      do_reset();
      bus(1'b0, 8'h1C, '0, 1'b0, rd, er);
      chk("R8 errresp", 64'(er), 64'd1);
      chk("R8 rdata zero", 64'(rd), 64'd0);
      chk("R10 masked irq low", 64'(irq_o), 64'd0);
      wr32(8'h00, 32'h8);
      chk("R10 irq after mask", 64'(irq_o), 64'd1);
      wr32(8'h00, 32'h28);
      chk("R10 cleared", 64'(irq_o), 64'd0);
      rd32(8'h00, rd); chk("R10 clear reads zero", 64'(rd), 64'h8);
      wr32(8'h00, 32'h18);
      bus(1'b1, 8'h12, 32'hFF, 1'b0, rd, er);
      chk("R8 errresp disabled", 64'(er), 64'd0);
      chk("R10 irq despite disable", 64'(irq_o), 64'd1);

      // R9 security mismatch has no effect
      do_reset();
      bus(1'b1, 8'h00, 32'h1, 1'b1, rd, er);
      chk("R9 errresp", 64'(er), 64'd1);
      rd32(8'h00, rd); chk("R9 ctrl untouched", 64'(rd), 64'd0);
      wr32(8'h08, 32'h55);
      bus(1'b0, 8'h08, '0, 1'b1, rd, er);
      chk("R9 read blocked", 64'(rd), 64'd0);
      wr32(8'h00, 32'h8);
      chk("R9 raised irq", 64'(irq_o), 64'd1);

      summary();
   end
endmodule